// File: doc/BRIEF.md
# XOR-Encoded Multi-Write Register File

This block is a register file that accepts several writes and several reads in every clock cycle, while its storage is made only of banks that each take a single write per cycle. There is one bank for each write port. A write port does not store its data as is: it stores the data XORed with the words that the other banks hold at the same address. The XOR of one address across all banks then yields the word last written there, whichever port wrote it. Each bank therefore carries, besides the read ports shared by the external readers, one extra combinational read port for every other write port, through which those writers fetch the words they need for encoding.

External reads are synchronous. An address presented in one cycle returns its word on the next cycle, sampled before any write at the same edge. The register file has no flow control. Every port is ready in every cycle and never applies back-pressure, so enables and addresses are plain control pins rather than valid/ready pairs. Callers must not send two writes to the same address in one cycle. If they do, the stored word is undefined and an assertion flags the conflict.

Top module: `xor_mp_regfile`

## Requirements
- R1: While reset is high and in the first cycles after it, every read port returns zero for every address until that address is written.
- R2: A read address presented in cycle t appears on that port's data output in cycle t+1, held in a register.
- R3: A write performed in cycle t is seen by any read whose address is presented in cycle t+1 or later. A read of the same address presented in cycle t itself returns the previous word.
- R4: Writes on different ports to distinct addresses in the same cycle all take effect.
- R5: Every read port is independent. Several ports reading the same address in one cycle all return the same word, and different addresses return their own words.
- R6: A write port whose enable is low changes nothing, whatever its address and data inputs carry.
- R7: A word written by any port fully replaces the previous word at that address, whichever port wrote the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears all banks and read outputs |
| wr_en | input | NW | Per-port write enable |
| wr_addr | input | NW × AW | Per-port write address, AW = clog2(DEPTH) |
| wr_data | input | NW × WIDTH | Per-port write data |
| rd_addr | input | NR × AW | Per-port read address |
| rd_data | output | NR × WIDTH | Per-port registered read data |

## Verification
On every cycle, the embedded assertions check the following. A write is returned unchanged by a read of its address issued in the next cycle. A steady read address with no write in the previous cycle yields steady data. Read data is zero on leaving reset. Two enabled write ports never share an address. The bench's scenarios cover the rest: the sweep of all addresses after reset, reads and writes to one address in the same cycle, ownership of a word passing back and forth between write ports, disabled ports driving garbage, and random multi-port traffic. In all of these, a behavioural model of the register contents is compared with every read port on every cycle.

// File: rtl/xrf_pkg.sv
package xrf_pkg;

  // Bank reached by write port g through its i-th peer lookup.
  function automatic int other_bank(input int g, input int i);
    return (i < g) ? i : i + 1;
  endfunction

  // Internal lookup slot on bank b that serves write port g (b != g).
  function automatic int bank_slot(input int b, input int g);
    return (g < b) ? g : g - 1;
  endfunction

  // Write port served by internal slot j of bank b.
  function automatic int slot_owner(input int b, input int j);
    return (j < b) ? j : j + 1;
  endfunction

endpackage

// File: rtl/xrf_bank.sv
module xrf_bank #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  parameter int NPORT = 5,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [AW-1:0]               waddr,
  input  logic [WIDTH-1:0]            wdata,
  input  logic [NPORT-1:0][AW-1:0]    raddr,
  output logic [NPORT-1:0][WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < DEPTH; e++) cells[e] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) rdata[p] = cells[raddr[p]];
  end

endmodule

// File: rtl/xrf_xor_fold.sv
module xrf_xor_fold #(
  parameter int N     = 2,
  parameter int WIDTH = 32
) (
  input  logic [N-1:0][WIDTH-1:0] words,
  output logic [WIDTH-1:0]        folded
);

  always_comb begin
    folded = '0;
    for (int n = 0; n < N; n++) folded = folded ^ words[n];
  end

endmodule

// File: rtl/xor_mp_regfile.sv
module xor_mp_regfile
  import xrf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  parameter int NR    = 4,
  parameter int NW    = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NW-1:0]            wr_en,
  input  logic [NW-1:0][AW-1:0]    wr_addr,
  input  logic [NW-1:0][WIDTH-1:0] wr_data,
  input  logic [NR-1:0][AW-1:0]    rd_addr,
  output logic [NR-1:0][WIDTH-1:0] rd_data
);

  localparam int NPEER  = NW - 1;
  localparam int BPORTS = NR + NPEER;

  logic [BPORTS-1:0][AW-1:0]    bank_ra [NW];
  logic [BPORTS-1:0][WIDTH-1:0] bank_rd [NW];
  logic [NW-1:0][WIDTH-1:0]     enc_data;
  logic [NR-1:0][WIDTH-1:0]     rd_next;

  // Banks: external read slots first, peer lookup slots after them
  for (genvar b = 0; b < NW; b++) begin : g_bank
    for (genvar p = 0; p < NR; p++) begin : g_ext
      assign bank_ra[b][p] = rd_addr[p];
    end
    for (genvar j = 0; j < NPEER; j++) begin : g_int
      assign bank_ra[b][NR+j] = wr_addr[slot_owner(b, j)];
    end
    xrf_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NPORT(BPORTS)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_en[b]),
      .waddr (wr_addr[b]),
      .wdata (enc_data[b]),
      .raddr (bank_ra[b]),
      .rdata (bank_rd[b])
    );
  end

  // Write encoding: data XOR peer banks' current words at the same address
  for (genvar g = 0; g < NW; g++) begin : g_wenc
    if (NW > 1) begin : g_multi
      logic [NPEER-1:0][WIDTH-1:0] peer;
      logic [WIDTH-1:0]            peer_x;
      for (genvar i = 0; i < NPEER; i++) begin : g_peer
        localparam int OB = other_bank(g, i);
        localparam int SL = NR + bank_slot(OB, g);
        assign peer[i] = bank_rd[OB][SL];
      end
      xrf_xor_fold #(.N(NPEER), .WIDTH(WIDTH)) u_fold (
        .words  (peer),
        .folded (peer_x)
      );
      assign enc_data[g] = wr_data[g] ^ peer_x;
    end else begin : g_single
      assign enc_data[g] = wr_data[g];
    end
  end

  // Read decoding: XOR across all banks, registered
  for (genvar k = 0; k < NR; k++) begin : g_rdec
    logic [NW-1:0][WIDTH-1:0] col;
    for (genvar b = 0; b < NW; b++) begin : g_col
      assign col[b] = bank_rd[b][k];
    end
    xrf_xor_fold #(.N(NW), .WIDTH(WIDTH)) u_fold (
      .words  (col),
      .folded (rd_next[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // ---------------- assertions ----------------
  logic [NW-1:0]            wen_q;
  logic [NW-1:0][AW-1:0]    waddr_q;
  logic [NW-1:0][WIDTH-1:0] wdata_q;
  logic [NR-1:0][AW-1:0]    raddr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wen_q   <= '0;
      waddr_q <= '0;
      wdata_q <= '0;
      raddr_q <= '0;
    end else begin
      wen_q   <= wr_en;
      waddr_q <= wr_addr;
      wdata_q <= wr_data;
      raddr_q <= rd_addr;
    end
  end

  assert_zero_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> rd_data == '0);

  for (genvar k = 0; k < NR; k++) begin : g_rd_chk
    // R6: no write last cycle and same address -> output unchanged
    assert_hold_without_write_R6: assert property (@(posedge clk) disable iff (rst)
      (wen_q == '0 && rd_addr[k] == raddr_q[k]) |=> $stable(rd_data[k]));
    for (genvar g = 0; g < NW; g++) begin : g_raw
      assert_write_visible_R3: assert property (@(posedge clk) disable iff (rst)
        (wen_q[g] && rd_addr[k] == waddr_q[g]) |=> rd_data[k] == $past(wdata_q[g]));
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_col_a
    for (genvar h = g + 1; h < NW; h++) begin : g_col_b
      assert_distinct_write_addr_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en[g] && wr_en[h]) |-> wr_addr[g] != wr_addr[h]);
    end
  end

endmodule

// File: tb/test_xor_mp_regfile.sv
module test_xor_mp_regfile;

  localparam int DEPTH = 32;
  localparam int WIDTH = 32;
  localparam int NR    = 4;
  localparam int NW    = 2;
  localparam int AW    = $clog2(DEPTH);

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic [NW-1:0]            wr_en = '0;
  logic [NW-1:0][AW-1:0]    wr_addr = '0;
  logic [NW-1:0][WIDTH-1:0] wr_data = '0;
  logic [NR-1:0][AW-1:0]    rd_addr = '0;
  logic [NR-1:0][WIDTH-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit armed = 1'b0;
  string req_tag = "R1";

  logic [WIDTH-1:0] ref_mem [DEPTH];
  logic [WIDTH-1:0] exp_rd  [NR];

  always #5 clk = ~clk;

  xor_mp_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NR(NR), .NW(NW)) i_xor_mp_regfile (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // Behavioural model: reads see contents before this edge's writes
  always @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < DEPTH; e++) ref_mem[e] = '0;
      for (int k = 0; k < NR; k++) exp_rd[k] = '0;
    end else begin
      for (int k = 0; k < NR; k++) exp_rd[k] = ref_mem[rd_addr[k]];
      for (int g = 0; g < NW; g++) if (wr_en[g]) ref_mem[wr_addr[g]] = wr_data[g];
    end
    armed = 1'b1;
  end

  task automatic compare_all();
    if (!armed) return;
    for (int k = 0; k < NR; k++) begin
      checks++;
      if (rd_data[k] !== exp_rd[k]) begin
        errors++;
        $display("FAIL %s read port %0d: actual %h expected %h", req_tag, k, rd_data[k], exp_rd[k]);
      end
    end
  endtask

  // Wait to the falling edge, compare, leave caller free to drive next inputs
  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_inputs();
    wr_en = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: during and after reset, all addresses read zero
    req_tag = "R1";
    for (int c = 0; c < 3; c++) step();
    rst = 1'b0;
    for (int a = 0; a < DEPTH; a += NR) begin
      for (int k = 0; k < NR; k++) rd_addr[k] = AW'(a + k);
      step();
    end
    step();

    // R2/R3: read same cycle as write returns old word; next cycle sees new
    req_tag = "R3";
    wr_en = 2'b01; wr_addr[0] = 5; wr_data[0] = 32'hA5A5_0001;
    for (int k = 0; k < NR; k++) rd_addr[k] = 5;
    step();
    idle_inputs();
    step();
    req_tag = "R2";
    rd_addr[0] = 5; rd_addr[1] = 0; rd_addr[2] = 5; rd_addr[3] = 1;
    step();
    step();

    // R4: both ports write distinct addresses at once
    req_tag = "R4";
    wr_en = 2'b11;
    wr_addr[0] = 7;  wr_data[0] = 32'h1111_2222;
    wr_addr[1] = 9;  wr_data[1] = 32'h3333_4444;
    step();
    idle_inputs();
    rd_addr[0] = 7; rd_addr[1] = 9; rd_addr[2] = 9; rd_addr[3] = 7;
    step();
    step();

    // R7: ownership of one address passes between ports
    req_tag = "R7";
    for (int r = 0; r < 6; r++) begin
      wr_en = (r % 2 == 0) ? 2'b01 : 2'b10;
      wr_addr[r % 2] = 12;
      wr_data[r % 2] = 32'hC0DE_0000 + r;
      wr_addr[(r + 1) % 2] = 3;
      for (int k = 0; k < NR; k++) rd_addr[k] = 12;
      step();
    end
    idle_inputs();
    step();
    step();

    // R6: disabled ports carry garbage aimed at written addresses
    req_tag = "R6";
    wr_en = '0;
    wr_addr[0] = 12; wr_data[0] = 32'hDEAD_BEEF;
    wr_addr[1] = 7;  wr_data[1] = 32'hBAD0_BAD0;
    rd_addr[0] = 12; rd_addr[1] = 7; rd_addr[2] = 9; rd_addr[3] = 5;
    for (int c = 0; c < 4; c++) step();

    // R5: all ports on one address, then all on different ones
    req_tag = "R5";
    for (int k = 0; k < NR; k++) rd_addr[k] = 9;
    step();
    step();
    for (int k = 0; k < NR; k++) rd_addr[k] = AW'(k * 3 + 5);
    step();
    step();

    // Random traffic on all ports, write addresses kept distinct
    req_tag = "R4/R7 random";
    for (int c = 0; c < 400; c++) begin
      for (int g = 0; g < NW; g++) begin
        wr_en[g]   = ($urandom % 3) != 0;
        wr_addr[g] = AW'($urandom % DEPTH);
        wr_data[g] = WIDTH'($urandom);
      end
      for (int g = 1; g < NW; g++)
        for (int h = 0; h < g; h++)
          if (wr_en[g] && wr_en[h] && wr_addr[g] == wr_addr[h]) wr_en[g] = 1'b0;
      for (int k = 0; k < NR; k++) rd_addr[k] = AW'($urandom % DEPTH);
      step();
    end
    idle_inputs();
    step();
    step();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule